// File: doc/BRIEF.md
# Four-Wire Test Access Port Controller

This block is the serial test port of a chip. It is clocked by its own test clock and steered by a mode-select line through the sixteen-state test-port state machine. Behind it sit a 4-bit instruction register, a one-stage bypass path and a 32-bit identification register. There is no dedicated test-reset input. The port returns to its reset state through the mode-select line or through the chip's power-on reset. There is no boundary-scan chain.

Two instruction values are decoded inside the block: `1110` selects the identification register and `1111` selects bypass. Any other value is placed on `ir_code` and flagged on `ext_sel`. External debug data registers then use the capture, shift and update strobes and return their serial bit on `ext_tdo`. The serial output changes on the falling test-clock edge. It comes with an enable that is high only while a register is being shifted.

Top module: `tap_ctrl`

## Requirements
- R1: While `por_n` is low the port is held in Test-Logic-Reset, `ir_code` reads 1110 and `tdo_en` and `tdo` are 0.
- R2: On each rising `tck` edge the state moves along the standard sixteen-state graph according to `tms`. The capture, shift and update strobes for the data path are high exactly in Capture-DR, Shift-DR and Update-DR.
- R3: Five rising edges with `tms` high bring the port to Test-Logic-Reset from any state. Every rising edge spent in that state loads 1110 into `ir_code`.
- R4: Capture-IR loads 0001 into the instruction shift stage, so the first bit shifted out is 1 and the next three are 0. Bits enter at the most significant end from `tdi` and leave at the least significant end.
- R5: `ir_code` takes the shifted value on the rising edge that leaves Update-IR, and changes on no other edge except in Test-Logic-Reset.
- R6: With `ir_code` = 1110, Capture-DR loads the identification value with bit 0 forced to 1. Shift-DR presents the value least significant bit first.
- R7: With `ir_code` = 1111, the bypass stage captures 0 and delays `tdi` by one shift.
- R8: For any other `ir_code`, `ext_sel` is 1 and `tdo` in Shift-DR carries `ext_tdo` as sampled on the falling edge.
- R9: `tdo` and `tdo_en` change only on falling `tck` edges. `tdo_en` is 1 only in Shift-DR or Shift-IR. `tdo` is 0 whenever `tdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| ext_tdo | input | 1 | Serial bit returned by an external data register |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | Output enable for `tdo` |
| ir_code | output | 4 | Current instruction |
| ext_sel | output | 1 | Instruction selects an external register |
| dr_capture | output | 1 | Port is in Capture-DR |
| dr_shift | output | 1 | Port is in Shift-DR |
| dr_update | output | 1 | Port is in Update-DR |

## Verification
The bench overrides the identification value with one whose bit 0 is clear, so it can observe the forced bit. The instruction width and the two decoded opcodes keep their defaults. With these values, opcode 0011 exercises the external-register path, and bypass and identification reads come out at their true lengths. A seeded random walk on `tms`, broken up by bursts of five or more ones, visits all sixteen states. A behavioural model tracks the walk and checks every output on every cycle.

// File: rtl/tap_ctrl.sv
module tap_ctrl #(
  parameter int          IR_W   = 4,
  parameter logic [31:0] IDCODE = 32'h0C3A_E01D,
  parameter logic [IR_W-1:0] ID_OP  = IR_W'(4'hE),
  parameter logic [IR_W-1:0] BYP_OP = IR_W'(4'hF)
) (
  input  logic            tck,
  input  logic            por_n,
  input  logic            tms,
  input  logic            tdi,
  input  logic            ext_tdo,
  output logic            tdo,
  output logic            tdo_en,
  output logic [IR_W-1:0] ir_code,
  output logic            ext_sel,
  output logic            dr_capture,
  output logic            dr_shift,
  output logic            dr_update
);
  localparam int ID_W = 32;
  localparam logic [IR_W-1:0] IR_CAP = IR_W'(1);
  localparam logic [ID_W-1:0] ID_VAL = IDCODE | ID_W'(1);

  typedef enum logic [3:0] {
    S_EX2_DR = 4'h0, S_EX1_DR = 4'h1, S_SH_DR  = 4'h2, S_PA_DR  = 4'h3,
    S_SEL_IR = 4'h4, S_UP_DR  = 4'h5, S_CAP_DR = 4'h6, S_SEL_DR = 4'h7,
    S_EX2_IR = 4'h8, S_EX1_IR = 4'h9, S_SH_IR  = 4'hA, S_PA_IR  = 4'hB,
    S_IDLE   = 4'hC, S_UP_IR  = 4'hD, S_CAP_IR = 4'hE, S_RESET  = 4'hF
  } tap_st_e;

  tap_st_e state, nxt;
  logic [IR_W-1:0] ir_sh;
  logic [ID_W-1:0] id_sh;
  logic            byp;
  logic            sel_id, sel_byp, dr_bit;

  always_comb begin
    unique case (state)
      S_RESET:  nxt = tms ? S_RESET  : S_IDLE;
      S_IDLE:   nxt = tms ? S_SEL_DR : S_IDLE;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nxt = tms ? S_UP_DR  : S_PA_DR;
      S_PA_DR:  nxt = tms ? S_EX2_DR : S_PA_DR;
      S_EX2_DR: nxt = tms ? S_UP_DR  : S_SH_DR;
      S_UP_DR:  nxt = tms ? S_SEL_DR : S_IDLE;
      S_SEL_IR: nxt = tms ? S_RESET  : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nxt = tms ? S_UP_IR  : S_PA_IR;
      S_PA_IR:  nxt = tms ? S_EX2_IR : S_PA_IR;
      S_EX2_IR: nxt = tms ? S_UP_IR  : S_SH_IR;
      S_UP_IR:  nxt = tms ? S_SEL_DR : S_IDLE;
      default:  nxt = S_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge por_n)
    if (!por_n) state <= S_RESET;
    else        state <= nxt;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_code <= ID_OP;
      ir_sh   <= IR_CAP;
    end else begin
      case (state)
        S_RESET:  ir_code <= ID_OP;
        S_CAP_IR: ir_sh   <= IR_CAP;
        S_SH_IR:  ir_sh   <= {tdi, ir_sh[IR_W-1:1]};
        S_UP_IR:  ir_code <= ir_sh;
        default: ;
      endcase
    end
  end

  assign sel_id  = (ir_code == ID_OP);
  assign sel_byp = (ir_code == BYP_OP);
  assign ext_sel = !sel_id && !sel_byp;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      id_sh <= ID_VAL;
      byp   <= 1'b0;
    end else if (state == S_CAP_DR) begin
      if (sel_id)  id_sh <= ID_VAL;
      if (sel_byp) byp   <= 1'b0;
    end else if (state == S_SH_DR) begin
      if (sel_id)  id_sh <= {tdi, id_sh[ID_W-1:1]};
      if (sel_byp) byp   <= tdi;
    end
  end

  assign dr_bit = sel_id ? id_sh[0] : (sel_byp ? byp : ext_tdo);

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == S_SH_DR) || (state == S_SH_IR);
      tdo    <= (state == S_SH_IR) ? ir_sh[0] :
                (state == S_SH_DR) ? dr_bit   : 1'b0;
    end
  end

  assign dr_capture = (state == S_CAP_DR);
  assign dr_shift   = (state == S_SH_DR);
  assign dr_update  = (state == S_UP_DR);
endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk #(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] ID_OP  = IR_W'(4'hE),
  parameter logic [IR_W-1:0] BYP_OP = IR_W'(4'hF)
) (
  input logic            tck,
  input logic            por_n,
  input logic            tms,
  input logic            tdo,
  input logic            tdo_en,
  input logic [IR_W-1:0] ir_code,
  input logic [3:0]      state,
  input logic [IR_W-1:0] ir_sh,
  input logic            byp
);
  localparam logic [3:0] C_RESET = 4'hF, C_SH_DR = 4'h2, C_SH_IR = 4'hA,
                         C_CAP_IR = 4'hE, C_UP_IR = 4'hD, C_CAP_DR = 4'h6;
  logic [2:0] ones;

  always_ff @(posedge tck or negedge por_n)
    if (!por_n)   ones <= '0;
    else if (!tms) ones <= '0;
    else if (ones != 3'd7) ones <= ones + 3'd1;

  assert_five_ones_reset_R3: assert property (@(posedge tck) disable iff (!por_n)
    (ones >= 3'd5) |-> (state == C_RESET));
  assert_reset_loads_id_R3: assert property (@(posedge tck) disable iff (!por_n)
    (state == C_RESET) |=> (ir_code == ID_OP));
  assert_capture_ir_R4: assert property (@(posedge tck) disable iff (!por_n)
    (state == C_CAP_IR) |=> (ir_sh == IR_W'(1)));
  assert_update_ir_R5: assert property (@(posedge tck) disable iff (!por_n)
    (state == C_UP_IR) |=> (ir_code == $past(ir_sh)));
  assert_ir_stable_R5: assert property (@(posedge tck) disable iff (!por_n)
    (state != C_UP_IR && state != C_RESET) |=> $stable(ir_code));
  assert_bypass_zero_R7: assert property (@(posedge tck) disable iff (!por_n)
    (state == C_CAP_DR && ir_code == BYP_OP) |=> (byp == 1'b0));
  assert_en_in_shift_R9: assert property (@(posedge tck) disable iff (!por_n)
    tdo_en |-> (state == C_SH_DR || state == C_SH_IR));
  assert_tdo_quiet_R9: assert property (@(posedge tck) disable iff (!por_n)
    !tdo_en |-> !tdo);
  assert_shift_hold_R2: assert property (@(posedge tck) disable iff (!por_n)
    (state == C_SH_DR && !tms) |=> (state == C_SH_DR));
endmodule

bind tap_ctrl tap_ctrl_chk #(.IR_W(IR_W), .ID_OP(ID_OP), .BYP_OP(BYP_OP)) chk (
  .tck(tck), .por_n(por_n), .tms(tms), .tdo(tdo), .tdo_en(tdo_en),
  .ir_code(ir_code), .state(state), .ir_sh(ir_sh), .byp(byp));

// File: tb/tap_ctrl_test.sv
module tap_ctrl_test;
  localparam logic [31:0] IDC = 32'h5A3C_96E4;
  localparam int TLR=0, RTI=1, SDS=2, CDR=3, SHDR=4, E1D=5, PDR=6, E2D=7,
                 UDR=8, SIS=9, CIR=10, SHIR=11, E1I=12, PIR=13, E2I=14, UIR=15;

  logic tck = 0, por_n = 0, tms = 1, tdi = 0, ext_tdo = 0;
  logic tdo, tdo_en, ext_sel, dr_capture, dr_shift, dr_update;
  logic [3:0] ir_code;
  int checks = 0, fails = 0;
  bit done = 0;

  tap_ctrl #(.IDCODE(IDC)) uut (.tck, .por_n, .tms, .tdi, .ext_tdo, .tdo, .tdo_en,
    .ir_code, .ext_sel, .dr_capture, .dr_shift, .dr_update);

  always #10 tck = ~tck;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nxt(int s, bit t);
    case (s)
      TLR:  return t ? TLR : RTI;   RTI:  return t ? SDS : RTI;
      SDS:  return t ? SIS : CDR;   CDR:  return t ? E1D : SHDR;
      SHDR: return t ? E1D : SHDR;  E1D:  return t ? UDR : PDR;
      PDR:  return t ? E2D : PDR;   E2D:  return t ? UDR : SHDR;
      UDR:  return t ? SDS : RTI;   SIS:  return t ? TLR : CIR;
      CIR:  return t ? E1I : SHIR;  SHIR: return t ? E1I : SHIR;
      E1I:  return t ? UIR : PIR;   PIR:  return t ? E2I : PIR;
      E2I:  return t ? UIR : SHIR;  default: return t ? SDS : RTI;
    endcase
  endfunction

  int m_st = TLR, m_ir = 14;
  bit m_irq[$], m_dq[$];
  bit m_tdo = 0, m_en = 0;

  always @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      m_st = TLR; m_ir = 14;
    end else begin
      case (m_st)
        TLR: m_ir = 14;
        CIR: m_irq = '{1, 0, 0, 0};
        SHIR: begin void'(m_irq.pop_front()); m_irq.push_back(tdi); end
        UIR: begin
          m_ir = 0;
          foreach (m_irq[i]) m_ir += int'(m_irq[i]) << i;
        end
        CDR: begin
          if (m_ir == 14) begin
            m_dq.delete();
            for (int i = 0; i < 32; i++) m_dq.push_back(i == 0 ? 1'b1 : IDC[i]);
          end else if (m_ir == 15) m_dq = '{0};
        end
        SHDR: if (m_ir >= 14) begin void'(m_dq.pop_front()); m_dq.push_back(tdi); end
        default: ;
      endcase
      m_st = nxt(m_st, tms);
    end
  end

  always @(negedge tck or negedge por_n) begin
    if (!por_n) begin m_en = 0; m_tdo = 0; end
    else begin
      m_en = (m_st == SHDR || m_st == SHIR);
      if (m_st == SHIR) m_tdo = m_irq[0];
      else if (m_st == SHDR) m_tdo = (m_ir >= 14) ? m_dq[0] : ext_tdo;
      else m_tdo = 0;
    end
  end

  always @(negedge tck) begin
    #9;
    if (por_n && !done) begin
      chk("R9 tdo_en", tdo_en, m_en);
      chk("R9 tdo", tdo, m_tdo);
      chk("R5 ir_code", ir_code, m_ir);
      chk("R2 strobes", {dr_capture, dr_shift, dr_update},
          {m_st == CDR, m_st == SHDR, m_st == UDR});
      chk("R8 ext_sel", ext_sel, m_ir < 14);
    end
  end

  task automatic step(input bit t, input bit d);
    @(negedge tck); #2; tms = t; tdi = d;
  endtask

  task automatic shift(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge tck); #2;
      dout[i] = tdo;
      tms = (i == n - 1); tdi = din[i];
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [31:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    shift(4, {28'h0, op}, cap);
  endtask

  task automatic read_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    step(1, 0); step(0, 0); step(0, 0);
    shift(n, din, dout);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] got;
    #35;
    chk("R1 reset ir_code", ir_code, 4'hE);
    chk("R1 reset tdo_en", tdo_en, 0);
    chk("R1 reset tdo", tdo, 0);
    @(negedge tck); #2; por_n = 1;
    step(0, 0);

    read_dr(32, 32'hFFFF_0000, got);
    chk("R6 id readout", got, IDC | 32'h1);

    load_ir(4'hF, got);
    chk("R4 captured ir", got[3:0], 4'b0001);
    @(negedge tck); #9;
    chk("R5 ir after update", ir_code, 4'hF);

    read_dr(9, 32'h0000_01B5, got);
    chk("R7 bypass", got[8:0], {8'hB5, 1'b0});

    load_ir(4'h3, got);
    @(negedge tck); #9;
    chk("R8 ext_sel", ext_sel, 1);
    ext_tdo = 1;
    read_dr(6, 32'h0, got);
    chk("R8 ext path", got[5:0], 6'h3F);
    ext_tdo = 0;

    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 6; i++) step(1, 0);
    @(negedge tck); #9;
    chk("R3 reset from shift ir_code", ir_code, 4'hE);
    chk("R3 reset from shift tdo_en", tdo_en, 0);

    void'($urandom(7));
    for (int blk = 0; blk < 40; blk++) begin
      for (int i = 0; i < 30; i++) step($urandom_range(0, 2) != 0 ? 0 : 1, 1'($urandom()));
      for (int i = 0; i < 6; i++) step(1, 0);
      @(negedge tck); #9;
      chk("R3 five ones", ir_code, 4'hE);
    end

    step(0, 0);
    @(negedge tck); #3; por_n = 0;
    #5;
    chk("R1 async reset tdo_en", tdo_en, 0);
    chk("R1 async reset ir_code", ir_code, 4'hE);
    #10;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule